// File: doc/BRIEF.md
# Local Scan Port Synchronizer

This block sits behind one upstream IEEE 1149.1 test access port and fans it out to a set of local scan chains. Every local port has its own controller. Each controller keeps a shadow copy of the TAP state that its local chain is in. A local port is either linked or parked. A linked port's TMS follows the upstream TMS, so its chain moves in step with the upstream TAP. A parked port's TMS is held low, so its chain stays frozen in Run-Test/Idle or Pause-DR.

Two commands drive the ports: a park request and an unpark request. Both are presented as levels and take effect on the clock edge that leaves Update-IR. An unpark request links the selected ports, but a port joins only on the edge where the upstream TAP enters the same state that the port is parked in. Ports parked in different states therefore join at different moments. A park request detaches every linked port on the edge where the upstream TAP enters the requested hold state.

The linked ports form one serial chain between the upstream TDI and TDO, with the lowest-numbered port nearest TDI. Parked ports are bypassed. The local chains share the upstream TCK and TRST.

Top module: `scan_port_hub`

## Requirements
- R1: While trst_n is low, and on release, every port is parked: port_linked is all zeros, every lsp_tms is 0 and tdo equals tdi.
- R2: A pending unpark is cancelled on the edge where the upstream TAP enters Test-Logic-Reset, so the port stays parked when the TAP later returns to Run-Test/Idle.
- R3: The unpark request is op_unpark high on the edge leaving Update-IR. A selected port parked in Run-Test/Idle links on that same edge when TMS is 0. From then on its lsp_tms equals tms.
- R4: If the TAP leaves Update-IR towards Select-DR-Scan, the selected port stays parked until the edge on which the upstream TAP enters Run-Test/Idle.
- R5: A selected port parked in Pause-DR stays parked until the edge where the upstream TAP enters Pause-DR, and links on that edge.
- R6: With one unpark request, selected ports parked in different states link on different edges, each when its own state is entered.
- R7: Bit i of port_sel (bit 0 = port 0) selects port i for an unpark request. Ports whose bit is 0 stay as they are.
- R8: Linked ports are chained in ascending order. Port 0 sees tdi when it is linked. Each later linked port sees the lsp_tdo of the nearest lower linked port. tdo is the lsp_tdo of the highest linked port.
- R9: A parked port's lsp_tdo has no effect on tdo.
- R10: The park request is op_park high on the edge leaving Update-IR, with park_in_pause choosing the hold state (0 = Run-Test/Idle, 1 = Pause-DR). Every linked port unlinks on the edge where the upstream TAP enters that state. After that its lsp_tms is 0 whatever tms is.
- R11: Each lsp_tck bit follows tck.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Upstream test clock |
| trst_n | input | 1 | Upstream test reset, active low, asynchronous |
| tms | input | 1 | Upstream mode select |
| tdi | input | 1 | Upstream serial data in |
| tdo | output | 1 | Upstream serial data out |
| op_park | input | 1 | Park request, sampled when leaving Update-IR |
| op_unpark | input | 1 | Unpark request, sampled when leaving Update-IR |
| park_in_pause | input | 1 | Park hold state: 0 Run-Test/Idle, 1 Pause-DR |
| port_sel | input | NUM_PORTS | Ports selected for unpark, bit i = port i |
| lsp_tck | output | NUM_PORTS | Test clock to each local chain |
| lsp_tms | output | NUM_PORTS | Mode select to each local chain |
| lsp_tdi | output | NUM_PORTS | Serial data into each local chain |
| lsp_tdo | input | NUM_PORTS | Serial data out of each local chain |
| port_linked | output | NUM_PORTS | 1 = port linked, 0 = port parked |

## Verification
Two things can happen on the same clock edge: an unpark request is taken in, and a port links. This occurs when the TAP steps straight from Update-IR into Run-Test/Idle while a selected port is parked there. The bench provokes it and expects port_linked to change on that very edge, not one edge later. A second case uses one request to select a port parked in Run-Test/Idle and a port parked in Pause-DR. The bench then judges each port's link edge on its own, together with lsp_tms following tms from that edge onwards.

// File: rtl/scan_hub_pkg.sv
package scan_hub_pkg;

   localparam int MAX_PORTS = 8;

   typedef enum logic [3:0] {
      TS_RESET,
      TS_IDLE,
      TS_DR_SEL,
      TS_DR_CAP,
      TS_DR_SHIFT,
      TS_DR_EX1,
      TS_DR_PAUSE,
      TS_DR_EX2,
      TS_DR_UPD,
      TS_IR_SEL,
      TS_IR_CAP,
      TS_IR_SHIFT,
      TS_IR_EX1,
      TS_IR_PAUSE,
      TS_IR_EX2,
      TS_IR_UPD
   } tap_state_e;

   // One step of the 1149.1 controller graph
   function automatic tap_state_e tap_step(tap_state_e s, logic m);
      tap_state_e n;
      case (s)
         TS_RESET:    n = m ? TS_RESET    : TS_IDLE;
         TS_IDLE:     n = m ? TS_DR_SEL   : TS_IDLE;
         TS_DR_SEL:   n = m ? TS_IR_SEL   : TS_DR_CAP;
         TS_DR_CAP:   n = m ? TS_DR_EX1   : TS_DR_SHIFT;
         TS_DR_SHIFT: n = m ? TS_DR_EX1   : TS_DR_SHIFT;
         TS_DR_EX1:   n = m ? TS_DR_UPD   : TS_DR_PAUSE;
         TS_DR_PAUSE: n = m ? TS_DR_EX2   : TS_DR_PAUSE;
         TS_DR_EX2:   n = m ? TS_DR_UPD   : TS_DR_SHIFT;
         TS_DR_UPD:   n = m ? TS_DR_SEL   : TS_IDLE;
         TS_IR_SEL:   n = m ? TS_RESET    : TS_IR_CAP;
         TS_IR_CAP:   n = m ? TS_IR_EX1   : TS_IR_SHIFT;
         TS_IR_SHIFT: n = m ? TS_IR_EX1   : TS_IR_SHIFT;
         TS_IR_EX1:   n = m ? TS_IR_UPD   : TS_IR_PAUSE;
         TS_IR_PAUSE: n = m ? TS_IR_EX2   : TS_IR_PAUSE;
         TS_IR_EX2:   n = m ? TS_IR_UPD   : TS_IR_SHIFT;
         TS_IR_UPD:   n = m ? TS_DR_SEL   : TS_IDLE;
         default:     n = TS_RESET;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/tap_shadow.sv
module tap_shadow
   import scan_hub_pkg::*;
(
   input  logic       tck,
   input  logic       trst_n,
   input  logic       tms_in,
   output tap_state_e state_q
);

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) state_q <= TS_RESET;
      else         state_q <= tap_step(state_q, tms_in);
   end

endmodule

// File: rtl/lsp_port_ctrl.sv
module lsp_port_ctrl
   import scan_hub_pkg::*;
#(
   parameter bit HOLD_TMS = 1'b0
)(
   input  logic       tck,
   input  logic       trst_n,
   input  logic       up_tms,
   input  tap_state_e up_state,
   input  tap_state_e up_next,
   input  logic       arm_unpark,
   input  logic       arm_park,
   input  tap_state_e park_tgt_now,
   input  tap_state_e park_tgt_q,
   output logic       linked,
   output logic       ltms
);

   tap_state_e loc_state;
   logic       linked_q;
   logic       unpark_pend_q;
   logic       park_pend_q;
   logic       loc_holdable;
   logic       going_reset;
   logic       unpark_go;
   logic       park_go;

   // Shadow of this port's local chain, fed by the TMS it actually receives
   tap_shadow u_local (
      .tck    (tck),
      .trst_n (trst_n),
      .tms_in (ltms),
      .state_q(loc_state)
   );

   assign ltms         = linked_q ? up_tms : HOLD_TMS;
   assign loc_holdable = (loc_state == TS_IDLE) || (loc_state == TS_DR_PAUSE);
   assign going_reset  = (up_next == TS_RESET);
   assign unpark_go    = (unpark_pend_q || arm_unpark) && !linked_q &&
                         loc_holdable && (up_next == loc_state);
   assign park_go      = (park_pend_q || arm_park) && linked_q &&
                         (up_next == park_tgt_now);

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         linked_q      <= 1'b0;
         unpark_pend_q <= 1'b0;
         park_pend_q   <= 1'b0;
      end else begin
         if (unpark_go)    linked_q <= 1'b1;
         else if (park_go) linked_q <= 1'b0;

         if (unpark_go || going_reset || arm_park) unpark_pend_q <= 1'b0;
         else if (arm_unpark && !linked_q)         unpark_pend_q <= 1'b1;

         if (park_go || going_reset || !linked_q) park_pend_q <= 1'b0;
         else if (arm_park)                       park_pend_q <= 1'b1;
      end
   end

   assign linked = linked_q;

   // R3
   lock_step_chk: assert property (@(posedge tck) disable iff (!trst_n)
      linked_q |-> (loc_state == up_state));

   // R5
   attach_from_park_chk: assert property (@(posedge tck) disable iff (!trst_n)
      $rose(linked_q) |-> ((loc_state == up_state) &&
                           (loc_state inside {TS_IDLE, TS_DR_PAUSE})));

   // R10
   park_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (!linked_q && (loc_state inside {TS_IDLE, TS_DR_PAUSE})) |=> $stable(loc_state));

   // R10
   detach_state_chk: assert property (@(posedge tck) disable iff (!trst_n)
      $fell(linked_q) |-> (loc_state == park_tgt_q));

endmodule

// File: rtl/scan_chain_route.sv
module scan_chain_route #(
   parameter int NUM_PORTS = 3
)(
   input  logic                 tdi,
   input  logic [NUM_PORTS-1:0] linked,
   input  logic [NUM_PORTS-1:0] lsp_tdo,
   output logic [NUM_PORTS-1:0] lsp_tdi,
   output logic                 tdo
);

   always_comb begin
      logic carry;
      carry = tdi;
      for (int i = 0; i < NUM_PORTS; i++) begin
         lsp_tdi[i] = carry;
         if (linked[i]) carry = lsp_tdo[i];
      end
      tdo = carry;
   end

endmodule

// File: rtl/scan_port_hub.sv
module scan_port_hub
   import scan_hub_pkg::*;
#(
   parameter int NUM_PORTS = 3,
   parameter bit HOLD_TMS  = 1'b0
)(
   input  logic                 tck,
   input  logic                 trst_n,
   input  logic                 tms,
   input  logic                 tdi,
   output logic                 tdo,
   input  logic                 op_park,
   input  logic                 op_unpark,
   input  logic                 park_in_pause,
   input  logic [NUM_PORTS-1:0] port_sel,
   output logic [NUM_PORTS-1:0] lsp_tck,
   output logic [NUM_PORTS-1:0] lsp_tms,
   output logic [NUM_PORTS-1:0] lsp_tdi,
   input  logic [NUM_PORTS-1:0] lsp_tdo,
   output logic [NUM_PORTS-1:0] port_linked
);

   generate
      if (NUM_PORTS < 1 || NUM_PORTS > MAX_PORTS) begin : g_bad_count
         $error("scan_port_hub: NUM_PORTS out of range");
      end
   endgenerate

   tap_state_e           up_state;
   tap_state_e           up_next;
   tap_state_e           tgt_q;
   tap_state_e           tgt_now;
   logic                 at_upd_ir;
   logic                 park_take;
   logic [NUM_PORTS-1:0] linked;

   tap_shadow u_upstream (
      .tck    (tck),
      .trst_n (trst_n),
      .tms_in (tms),
      .state_q(up_state)
   );

   assign up_next   = tap_step(up_state, tms);
   assign at_upd_ir = (up_state == TS_IR_UPD);
   assign park_take = at_upd_ir && op_park;
   assign tgt_now   = park_take ? (park_in_pause ? TS_DR_PAUSE : TS_IDLE) : tgt_q;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) tgt_q <= TS_IDLE;
      else         tgt_q <= tgt_now;
   end

   for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
      lsp_port_ctrl #(
         .HOLD_TMS(HOLD_TMS)
      ) u_port (
         .tck         (tck),
         .trst_n      (trst_n),
         .up_tms      (tms),
         .up_state    (up_state),
         .up_next     (up_next),
         .arm_unpark  (at_upd_ir && op_unpark && port_sel[i]),
         .arm_park    (park_take),
         .park_tgt_now(tgt_now),
         .park_tgt_q  (tgt_q),
         .linked      (linked[i]),
         .ltms        (lsp_tms[i])
      );
   end

   scan_chain_route #(
      .NUM_PORTS(NUM_PORTS)
   ) u_route (
      .tdi    (tdi),
      .linked (linked),
      .lsp_tdo(lsp_tdo),
      .lsp_tdi(lsp_tdi),
      .tdo    (tdo)
   );

   assign lsp_tck     = {NUM_PORTS{tck}};
   assign port_linked = linked;

endmodule

// File: tb/scan_port_hub_test.sv
module scan_port_hub_test;

   localparam int PERIOD = 20;
   localparam int NP     = 3;

   logic          tck = 1'b0;
   logic          trst_n = 1'b0;
   logic          tms = 1'b1;
   logic          tdi = 1'b0;
   logic          tdo;
   logic          op_park = 1'b0;
   logic          op_unpark = 1'b0;
   logic          park_in_pause = 1'b0;
   logic [NP-1:0] port_sel = '0;
   logic [NP-1:0] lsp_tck;
   logic [NP-1:0] lsp_tms;
   logic [NP-1:0] lsp_tdi;
   logic [NP-1:0] lsp_tdo = '0;
   logic [NP-1:0] port_linked;

   int  n_cmp = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;

   typedef struct {
      logic [NP-1:0] lk;
      string         tag;
   } exp_t;
   exp_t q[$];

   scan_port_hub #(.NUM_PORTS(NP)) uut (
      .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
      .op_park(op_park), .op_unpark(op_unpark), .park_in_pause(park_in_pause),
      .port_sel(port_sel), .lsp_tck(lsp_tck), .lsp_tms(lsp_tms),
      .lsp_tdi(lsp_tdi), .lsp_tdo(lsp_tdo), .port_linked(port_linked)
   );

   always #(PERIOD/2) tck = ~tck;

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      end
   endtask

   // Driver: one TCK cycle with the given TMS and the expected link set after the edge
   task automatic step(input logic t, input logic [NP-1:0] exp, input string tag);
      exp_t it;
      @(negedge tck);
      tms = t;
      it.lk  = exp;
      it.tag = tag;
      q.push_back(it);
      @(posedge tck);
      #1;
   endtask

   // Idle -> Update-IR
   task automatic to_upd_ir(input logic [NP-1:0] exp, input string tag);
      step(1'b1, exp, tag);
      step(1'b1, exp, tag);
      step(1'b0, exp, tag);
      step(1'b1, exp, tag);
      step(1'b1, exp, tag);
   endtask

   task automatic clear_ops();
      op_park   = 1'b0;
      op_unpark = 1'b0;
      port_sel  = '0;
   endtask

   // Monitor: compares link status and local TMS after each edge
   initial begin
      forever begin
         @(posedge tck);
         #(PERIOD/4);
         if (q.size() > 0) begin
            exp_t it;
            logic [NP-1:0] etms;
            it = q.pop_front();
            for (int i = 0; i < NP; i++) etms[i] = it.lk[i] ? tms : 1'b0;
            chk({it.tag, " linked"}, 8'(port_linked), 8'(it.lk));
            chk({it.tag, " lsp_tms"}, 8'(lsp_tms), 8'(etms));
         end
      end
   end

   initial begin
      #(PERIOD*4000);
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      // R1 reset state
      #(PERIOD*2 + 3);
      tdi = 1'b1;
      #1;
      chk("R1 reset linked", 8'(port_linked), 8'h00);
      chk("R1 reset lsp_tms", 8'(lsp_tms), 8'h00);
      chk("R1 reset tdo=tdi", 8'(tdo), 8'h01);
      tdi = 1'b0;
      #1;
      chk("R1 reset tdo=tdi low", 8'(tdo), 8'h00);
      // R11 clock pass-through in both phases
      @(posedge tck); #2;
      chk("R11 lsp_tck high", 8'(lsp_tck), 8'h07);
      @(negedge tck); #2;
      chk("R11 lsp_tck low", 8'(lsp_tck), 8'h00);
      trst_n = 1'b1;
      step(1'b0, 3'b000, "R1");

      // R3 unpark port 0, Update-IR straight into Idle
      to_upd_ir(3'b000, "R3");
      op_unpark = 1'b1; port_sel = 3'b001;
      step(1'b0, 3'b001, "R3");
      clear_ops();
      step(1'b1, 3'b001, "R3");
      step(1'b0, 3'b001, "R3");
      step(1'b1, 3'b001, "R3");
      step(1'b1, 3'b001, "R3");
      step(1'b0, 3'b001, "R3");

      // R10 park port 0 in Pause-DR
      to_upd_ir(3'b001, "R10");
      op_park = 1'b1; park_in_pause = 1'b1;
      step(1'b1, 3'b001, "R10");
      clear_ops();
      step(1'b0, 3'b001, "R10");
      step(1'b1, 3'b001, "R10");
      step(1'b0, 3'b000, "R10");
      step(1'b1, 3'b000, "R10");
      step(1'b1, 3'b000, "R10");
      step(1'b0, 3'b000, "R10");

      // R4 and R7: select port 1 only, leave via Select-DR
      to_upd_ir(3'b000, "R4");
      op_unpark = 1'b1; port_sel = 3'b010;
      step(1'b1, 3'b000, "R4");
      clear_ops();
      step(1'b0, 3'b000, "R4");
      step(1'b1, 3'b000, "R4");
      step(1'b1, 3'b000, "R4");
      step(1'b0, 3'b010, "R7");

      // R9: parked outputs do not reach tdo; R8 with port 1 alone
      tdi = 1'b0; lsp_tdo = 3'b010;
      #1;
      chk("R8 tdo from port 1", 8'(tdo), 8'h01);
      chk("R8 port1 tdi from tdi", 8'(lsp_tdi[1]), 8'h00);
      lsp_tdo = 3'b101;
      #1;
      chk("R9 parked tdo ignored", 8'(tdo), 8'h00);

      // R6 and R5: port 2 parked in Idle, port 0 parked in Pause-DR
      to_upd_ir(3'b010, "R6");
      op_unpark = 1'b1; port_sel = 3'b101;
      step(1'b0, 3'b110, "R6");
      clear_ops();
      step(1'b1, 3'b110, "R5");
      step(1'b0, 3'b110, "R5");
      step(1'b1, 3'b110, "R5");
      step(1'b0, 3'b111, "R5");
      step(1'b1, 3'b111, "R6");
      step(1'b1, 3'b111, "R6");
      step(1'b0, 3'b111, "R6");

      // R8: full chain order
      tdi = 1'b1; lsp_tdo = 3'b010;
      #1;
      chk("R8 port0 tdi", 8'(lsp_tdi[0]), 8'h01);
      chk("R8 port1 tdi", 8'(lsp_tdi[1]), 8'h00);
      chk("R8 port2 tdi", 8'(lsp_tdi[2]), 8'h01);
      chk("R8 tdo", 8'(tdo), 8'h00);
      lsp_tdo = 3'b100;
      #1;
      chk("R8 tdo from top port", 8'(tdo), 8'h01);

      // R10 park all in Idle
      to_upd_ir(3'b111, "R10");
      op_park = 1'b1; park_in_pause = 1'b0;
      step(1'b0, 3'b000, "R10");
      clear_ops();
      step(1'b1, 3'b000, "R10");
      step(1'b0, 3'b000, "R10");
      step(1'b1, 3'b000, "R10");
      step(1'b1, 3'b000, "R10");
      step(1'b0, 3'b000, "R10");

      // R2 pending unpark cancelled by Test-Logic-Reset
      to_upd_ir(3'b000, "R2");
      op_unpark = 1'b1; port_sel = 3'b001;
      step(1'b1, 3'b000, "R2");
      clear_ops();
      step(1'b1, 3'b000, "R2");
      step(1'b1, 3'b000, "R2");
      step(1'b0, 3'b000, "R2");
      step(1'b0, 3'b000, "R2");

      // R1 reset while linked
      to_upd_ir(3'b000, "R3");
      op_unpark = 1'b1; port_sel = 3'b111;
      step(1'b0, 3'b111, "R3");
      clear_ops();
      @(negedge tck);
      trst_n = 1'b0;
      tdi = 1'b1;
      #2;
      chk("R1 linked after trst", 8'(port_linked), 8'h00);
      chk("R1 tdo after trst", 8'(tdo), 8'h01);
      chk("R1 lsp_tms after trst", 8'(lsp_tms), 8'h00);

      repeat (3) @(posedge tck);
      #(PERIOD/2);
      summary();
      $finish;
   end

endmodule